// File: doc/BRIEF.md
# Framed Serial Command Receiver

This block accepts 24-bit command words over a three-wire link made of an active-low select, a serial clock and a data line. All three wires are brought into the system clock domain through two-flop synchronisers. The serial clock and the select are then edge-detected there. Each completed word is split into a 16-bit code, a 4-bit channel number and two mode bits. The block then issues a one-cycle write toward a 16-entry code store. The select may stay low across any number of back-to-back words, and each word is written as soon as its last bit arrives.

The two mode bits are held in a latch that is reloaded by every written word. One bit chooses immediate versus burst update and the other chooses the external versus internal sequencer clock. Each latched bit is ORed with a matching external pin, so a 1 on either side wins. The block tells the sequencer when a frame opens and closes. A frame that closes part way through a word is flagged and nothing is written. While the downstream reset fill is running, the serial wires are ignored entirely.

The system clock must run at least four times faster than the serial clock.

Top module: `cmd_rx_top`

## Requirements
- R1: Data is taken on each rising edge of the serial clock while the select is low, most significant bit first. The first rising edge after the select falls carries bit 23, and the bit counter restarts at every select fall.
- R2: Bit fields of a word: bits 23..8 are the code (bit 23 is the code MSB), bits 7..4 are the channel (bit 7 is its MSB), bit 3 must be 0, bit 2 is the update-mode bit, bit 1 is the clock-select bit, and bit 0 must be 0. The code appears on `wr_data_o` and the channel on `wr_addr_o`.
- R3: Each completed group of 24 bits produces exactly one single-cycle `wr_en_o` pulse.
- R4: Several complete words sent within one select-low frame are each written, in arrival order.
- R5: The update-mode and clock-select bits are re-latched by every written word. A clock-select of 1 stays in effect only while each following word repeats it.
- R6: `immed_mode_o` is the OR of the latched update-mode bit and `imm_pin_i`, and `ext_clk_o` is the OR of the latched clock-select bit and `eclk_pin_i`. Each output follows its inputs one system clock later.
- R7: While `fill_busy_i` is high, select edges and serial clock edges are ignored. No write, no frame pulse and no error are produced.
- R8: A frame that closes with a bit count that is not a multiple of 24 writes nothing for the partial word and pulses `part_err_o` together with `frame_end_o`.
- R9: A word with bit 3 or bit 0 set pulses `fmt_err_o` in the same cycle as its `wr_en_o`, and the word is still written.
- R10: `frame_start_o` pulses once for each select fall and `frame_end_o` pulses once for each select rise of an accepted frame.
- R11: After reset, all outputs are 0 and the mode latch is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| csn_i | input | 1 | Active-low frame select, asynchronous |
| sdi_i | input | 1 | Serial data, asynchronous |
| fill_busy_i | input | 1 | High while the reset fill runs; serial input ignored |
| imm_pin_i | input | 1 | External force of immediate update mode |
| eclk_pin_i | input | 1 | External force of external sequencer clock |
| wr_en_o | output | 1 | One-cycle write strobe to the code store |
| wr_addr_o | output | 4 | Channel to write |
| wr_data_o | output | 16 | Code to write |
| fmt_err_o | output | 1 | Pulse with a write whose fixed-zero bits were not zero |
| part_err_o | output | 1 | Pulse at frame end when a partial word was discarded |
| frame_start_o | output | 1 | Pulse when an accepted frame opens |
| frame_end_o | output | 1 | Pulse when an accepted frame closes |
| immed_mode_o | output | 1 | Effective immediate-update mode |
| ext_clk_o | output | 1 | Effective external sequencer clock select |

## Verification
The assertions check on every cycle the properties that do not depend on the data:
- the bit counter never leaves its range;
- write strobes are isolated single pulses;
- a format error never appears without a write, and a partial-word error never appears without a frame end;
- nothing starts while the fill is busy;
- each mode output follows its pin one cycle later.

Only the bench scenarios can show the data-dependent behaviour:
- that bits land in the right fields in MSB-first order;
- that several words in one frame are each written;
- that a partial word is dropped and the next frame starts from a fresh count;
- that a clock-select bit lapses when a later word does not repeat it.

// File: rtl/cmd_rx_pkg.sv
package cmd_rx_pkg;
  // Trailing control field of a command word, below the channel number.
  localparam int TAIL_W    = 4;
  localparam int ZERO_HI   = 3;  // must be 0
  localparam int MODE_POS  = 2;  // 1 = immediate update, 0 = burst
  localparam int CKSEL_POS = 1;  // 1 = external sequencer clock
  localparam int ZERO_LO   = 0;  // must be 0

  typedef struct packed {
    logic mode;
    logic cksel;
    logic bad_fmt;
  } tail_t;

  function automatic tail_t split_tail(input logic [TAIL_W-1:0] t);
    tail_t r;
    r.mode    = t[MODE_POS];
    r.cksel   = t[CKSEL_POS];
    r.bad_fmt = t[ZERO_HI] | t[ZERO_LO];
    return r;
  endfunction
endpackage

// File: rtl/cmd_rx_sync.sv
module cmd_rx_sync #(
  parameter int          N       = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  logic [N-1:0] meta_q;
  logic [N-1:0] stab_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= RST_VAL[g];
        stab_q[g] <= RST_VAL[g];
      end else begin
        meta_q[g] <= async_i[g];
        stab_q[g] <= meta_q[g];
      end
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/cmd_rx_shifter.sv
module cmd_rx_shifter #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              csn_s,
  input  logic              sdi_s,
  input  logic              fill_busy,
  output logic [WORD_W-1:0] word_o,
  output logic              word_done_o,
  output logic              frame_start_o,
  output logic              frame_end_o,
  output logic              part_err_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic             sclk_d, csn_d;
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WORD_W-1:0] sh_q;

  // Named edge events for the assertions.
  logic sclk_rise, cs_fall, cs_rise, take_bit;
  assign sclk_rise = sclk_s & ~sclk_d;
  assign cs_fall   = ~csn_s & csn_d;
  assign cs_rise   = csn_s & ~csn_d;
  assign take_bit  = sclk_rise & active_q & ~fill_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d        <= 1'b0;
      csn_d         <= 1'b1;
      active_q      <= 1'b0;
      cnt_q         <= '0;
      sh_q          <= '0;
      word_o        <= '0;
      word_done_o   <= 1'b0;
      frame_start_o <= 1'b0;
      frame_end_o   <= 1'b0;
      part_err_o    <= 1'b0;
    end else begin
      sclk_d        <= sclk_s;
      csn_d         <= csn_s;
      word_done_o   <= 1'b0;
      frame_start_o <= 1'b0;
      frame_end_o   <= 1'b0;
      part_err_o    <= 1'b0;
      if (cs_fall && !fill_busy) begin
        active_q      <= 1'b1;
        cnt_q         <= '0;
        frame_start_o <= 1'b1;
      end else if (cs_rise && active_q) begin
        active_q    <= 1'b0;
        frame_end_o <= 1'b1;
        part_err_o  <= (cnt_q != '0);
        cnt_q       <= '0;
      end else if (take_bit) begin
        sh_q <= {sh_q[WORD_W-2:0], sdi_s};
        if (cnt_q == LAST_BIT) begin
          cnt_q       <= '0;
          word_done_o <= 1'b1;
          word_o      <= {sh_q[WORD_W-2:0], sdi_s};
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_BIT);
  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    word_done_o |=> !word_done_o);
  assert_part_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    part_err_o |-> frame_end_o);
  assert_busy_no_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && fill_busy) |=> !frame_start_o);
  assert_busy_no_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_busy |=> !word_done_o);
  assert_start_end_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_start_o && frame_end_o));
endmodule

// File: rtl/cmd_rx_decode.sv
module cmd_rx_decode
  import cmd_rx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int WORD_W = DATA_W + ADDR_W + TAIL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_done_i,
  input  logic              imm_pin_i,
  input  logic              eclk_pin_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              fmt_err_o,
  output logic              immed_mode_o,
  output logic              ext_clk_o
);
  function automatic logic [DATA_W-1:0] code_of(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: DATA_W];
  endfunction

  function automatic logic [ADDR_W-1:0] chan_of(input logic [WORD_W-1:0] w);
    return w[TAIL_W +: ADDR_W];
  endfunction

  tail_t tail;
  logic  mode_q, cksel_q;
  logic  mode_nx, cksel_nx;

  assign tail     = split_tail(word_i[TAIL_W-1:0]);
  assign mode_nx  = word_done_i ? tail.mode  : mode_q;
  assign cksel_nx = word_done_i ? tail.cksel : cksel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_o      <= 1'b0;
      wr_addr_o    <= '0;
      wr_data_o    <= '0;
      fmt_err_o    <= 1'b0;
      mode_q       <= 1'b0;
      cksel_q      <= 1'b0;
      immed_mode_o <= 1'b0;
      ext_clk_o    <= 1'b0;
    end else begin
      wr_en_o      <= word_done_i;
      fmt_err_o    <= word_done_i & tail.bad_fmt;
      if (word_done_i) begin
        wr_addr_o <= chan_of(word_i);
        wr_data_o <= code_of(word_i);
      end
      mode_q       <= mode_nx;
      cksel_q      <= cksel_nx;
      immed_mode_o <= mode_nx | imm_pin_i;
      ext_clk_o    <= cksel_nx | eclk_pin_i;
    end
  end

  assert_pin_imm_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    imm_pin_i |=> immed_mode_o);
  assert_pin_eclk_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eclk_pin_i |=> ext_clk_o);
  assert_fmt_with_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err_o |-> wr_en_o);
  assert_write_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);
  assert_cksel_relatch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done_i && !word_i[CKSEL_POS] && !eclk_pin_i) |=> !ext_clk_o);
endmodule

// File: rtl/cmd_rx_top.sv
module cmd_rx_top #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              sdi_i,
  input  logic              fill_busy_i,
  input  logic              imm_pin_i,
  input  logic              eclk_pin_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              fmt_err_o,
  output logic              part_err_o,
  output logic              frame_start_o,
  output logic              frame_end_o,
  output logic              immed_mode_o,
  output logic              ext_clk_o
);
  localparam int WORD_W = DATA_W + ADDR_W + cmd_rx_pkg::TAIL_W;

  // Synchroniser lanes: [2] = serial clock, [1] = select, [0] = data.
  logic [2:0] raw, syn;
  assign raw = {sclk_i, csn_i, sdi_i};

  logic [WORD_W-1:0] word;
  logic              word_done;

  cmd_rx_sync #(.N(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(raw), .sync_o(syn)
  );

  cmd_rx_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(syn[2]), .csn_s(syn[1]), .sdi_s(syn[0]),
    .fill_busy(fill_busy_i),
    .word_o(word), .word_done_o(word_done),
    .frame_start_o(frame_start_o), .frame_end_o(frame_end_o),
    .part_err_o(part_err_o)
  );

  cmd_rx_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .word_i(word), .word_done_i(word_done),
    .imm_pin_i(imm_pin_i), .eclk_pin_i(eclk_pin_i),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .fmt_err_o(fmt_err_o),
    .immed_mode_o(immed_mode_o), .ext_clk_o(ext_clk_o)
  );
endmodule

// File: tb/tb_cmd_rx_top.sv
`timescale 1ns/1ps
module tb_cmd_rx_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, sdi = 1'b0;
  logic fill = 1'b0, ipin = 1'b0, epin = 1'b0;
  logic        wr_en, fmt_err, part_err, fstart, fend, immed, extc;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;

  always #2.5 clk = ~clk;

  cmd_rx_top dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi),
    .fill_busy_i(fill), .imm_pin_i(ipin), .eclk_pin_i(epin),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .fmt_err_o(fmt_err), .part_err_o(part_err),
    .frame_start_o(fstart), .frame_end_o(fend),
    .immed_mode_o(immed), .ext_clk_o(extc)
  );

  // Write and event monitor.
  int          n_wr = 0, n_part = 0, n_start = 0, n_end = 0, n_fmt = 0;
  logic [3:0]  last_addr = '0;
  logic [15:0] last_data = '0;
  logic [15:0] prev_data = '0;
  always @(posedge clk) begin
    if (wr_en) begin
      n_wr <= n_wr + 1;
      prev_data <= last_data;
      last_addr <= wr_addr;
      last_data <= wr_data;
    end
    if (fmt_err) n_fmt <= n_fmt + 1;
    if (part_err) n_part <= n_part + 1;
    if (fstart) n_start <= n_start + 1;
    if (fend) n_end <= n_end + 1;
  end

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Send nbits from the top of bits (bit 71 first) in one frame.
  task automatic send_frame(input logic [71:0] bits, input int nbits);
    csn = 1'b0;
    wait_clk(8);
    for (int i = 0; i < nbits; i++) begin
      sdi = bits[71-i];
      wait_clk(8);
      sclk = 1'b1;
      wait_clk(8);
      sclk = 1'b0;
    end
    wait_clk(8);
    csn = 1'b1;
    wait_clk(20);
  endtask

  function automatic logic [23:0] mk(input logic [15:0] d, input logic [3:0] a,
                                     input logic m, input logic c);
    return {d, a, 1'b0, m, c, 1'b0};
  endfunction

  // Vector table: one word per frame; expected fields are taken from the R2 layout.
  localparam logic [23:0] VEC [0:7] = '{
    24'hA5C300, 24'hFFFFF0, 24'h000010, 24'h123454,
    24'h8001A2, 24'h7FFE66, 24'h0F0F30, 24'hC3C3E4
  };

  initial begin
    int wr0, st0, en0, pt0, fm0;
    wait_clk(4);
    // R11: reset state
    chk("R11 wr_en", int'(wr_en), 0);
    chk("R11 immed", int'(immed), 0);
    chk("R11 ext_clk", int'(extc), 0);
    chk("R11 frame pulses", int'({fstart, fend, part_err, fmt_err}), 0);
    rst_n = 1'b1;
    wait_clk(4);

    // R1 R2 R3 R5 R10: vector walk
    for (int v = 0; v < 8; v++) begin
      wr0 = n_wr; st0 = n_start; en0 = n_end;
      send_frame({VEC[v], 48'h0}, 24);
      chk("R3 one write per word", n_wr - wr0, 1);
      chk("R2 data field", int'(last_data), int'(VEC[v][23:8]));
      chk("R2 addr field", int'(last_addr), int'(VEC[v][7:4]));
      chk("R5 immed latch", int'(immed), int'(VEC[v][2]));
      chk("R5 ext clock latch", int'(extc), int'(VEC[v][1]));
      chk("R10 frame start", n_start - st0, 1);
      chk("R10 frame end", n_end - en0, 1);
    end

    // R4: three words in one frame
    wr0 = n_wr; st0 = n_start;
    send_frame({mk(16'h1111, 4'h3, 0, 0), mk(16'h2222, 4'h9, 0, 0),
                mk(16'h3333, 4'hC, 1, 0)}, 72);
    chk("R4 writes in frame", n_wr - wr0, 3);
    chk("R4 last data", int'(last_data), 16'h3333);
    chk("R4 second data", int'(prev_data), 16'h2222);
    chk("R4 last addr", int'(last_addr), 4'hC);
    chk("R10 single start", n_start - st0, 1);

    // R8: partial word discarded
    wr0 = n_wr; pt0 = n_part;
    send_frame({mk(16'hDEAD, 4'h5, 0, 0), 48'h0}, 10);
    chk("R8 no write", n_wr - wr0, 0);
    chk("R8 error pulse", n_part - pt0, 1);
    // R1: next frame starts counting afresh
    send_frame({mk(16'hBEEF, 4'h2, 0, 0), 48'h0}, 24);
    chk("R1 fresh count data", int'(last_data), 16'hBEEF);
    chk("R1 fresh count addr", int'(last_addr), 4'h2);
    // R8: 30 bits = one word plus partial
    wr0 = n_wr; pt0 = n_part;
    send_frame({mk(16'h4444, 4'h7, 0, 0), mk(16'h5555, 4'h8, 0, 0), 24'h0}, 30);
    chk("R8 full word kept", n_wr - wr0, 1);
    chk("R8 partial flagged", n_part - pt0, 1);

    // R7: fill busy ignores serial input
    fill = 1'b1;
    wr0 = n_wr; st0 = n_start; en0 = n_end; pt0 = n_part;
    send_frame({mk(16'h9999, 4'hE, 1, 1), 48'h0}, 24);
    chk("R7 no write", n_wr - wr0, 0);
    chk("R7 no start", n_start - st0, 0);
    chk("R7 no end", n_end - en0, 0);
    chk("R7 no error", n_part - pt0, 0);
    chk("R7 mode untouched", int'(extc), 0);
    fill = 1'b0;
    wait_clk(4);

    // R6: pins OR with latched bits (latched both 0 now)
    send_frame({mk(16'h0001, 4'h0, 0, 0), 48'h0}, 24);
    ipin = 1'b1; wait_clk(3);
    chk("R6 imm pin wins", int'(immed), 1);
    chk("R6 ext stays low", int'(extc), 0);
    ipin = 1'b0; epin = 1'b1; wait_clk(3);
    chk("R6 imm pin released", int'(immed), 0);
    chk("R6 eclk pin wins", int'(extc), 1);
    epin = 1'b0; wait_clk(3);
    chk("R6 eclk pin released", int'(extc), 0);

    // R5: clock select lapses when not repeated
    send_frame({mk(16'h0002, 4'h1, 0, 1), 48'h0}, 24);
    chk("R5 ext clock set", int'(extc), 1);
    send_frame({mk(16'h0003, 4'h1, 0, 0), 48'h0}, 24);
    chk("R5 ext clock lapses", int'(extc), 0);

    // R9: fixed-zero bits violated, still written
    wr0 = n_wr; fm0 = n_fmt;
    send_frame({24'h6789A8, 48'h0}, 24);
    chk("R9 bit3 written", n_wr - wr0, 1);
    chk("R9 bit3 flagged", n_fmt - fm0, 1);
    chk("R9 bit3 data", int'(last_data), 16'h6789);
    wr0 = n_wr; fm0 = n_fmt;
    send_frame({24'h2468B1, 48'h0}, 24);
    chk("R9 bit0 written", n_wr - wr0, 1);
    chk("R9 bit0 flagged", n_fmt - fm0, 1);
    chk("R9 bit0 addr", int'(last_addr), 4'hB);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule